// File: doc/BRIEF.md
# Eight-Point Fixed-Point Row Inverse DCT

This block takes one row of eight signed 16-bit transform coefficients and returns the eight signed 16-bit samples of its one-dimensional inverse DCT. The arithmetic follows a single integer convention, so the results are bit-exact. The cosine weights are fixed 14-bit fractional constants that carry a sqrt(2) factor. The row is split into an even half, which uses coefficients 0, 2, 4 and 6, and an odd half, which uses coefficients 1, 3, 5 and 7. Each half is built as four weighted sums. The block then forms butterflies, adds a rounding bias, shifts right by 11 and keeps the low 16 bits. The surrounding logic does the transpose, walks the rows and clips the pixels. This block does none of those.

A row enters as one parallel vector through a valid/ready handshake. The block holds one row at a time. The row is registered first. The weighted sums are registered next, and the butterflies and the shift come last, so each result appears three cycles after the row is accepted. While a row is in flight, `in_ready` stays low. A row whose seven AC coefficients are all zero takes a shortcut: the multipliers are not used, and every lane receives a copy of the scaled DC value.

Top module: `idct8_row`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and `out_data` is all zero.
- R2: A row is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is then 0 for the next two cycles, and any `in_valid` during those cycles is ignored.
- R3: `out_valid` is 1 for exactly one cycle, three cycles after the row was accepted. In that cycle `in_ready` is 1 again. Rows come out in the order they were accepted.
- R4: Coefficient k sits at `in_coef[16k+15:16k]` and result k sits at `out_data[16k+15:16k]`, both in two's complement. The weights are c1=22725, c2=21407, c3=19266, c4=16383, c5=12873, c6=8867 and c7=4520.
- R5: The even sums, each including the bias 1024, are:
  - e0=c4x0+c2x2+c4x4+c6x6+1024
  - e1=c4x0+c6x2-c4x4-c2x6+1024
  - e2=c4x0-c6x2-c4x4+c2x6+1024
  - e3=c4x0-c2x2+c4x4-c6x6+1024
- R6: The odd sums are:
  - o0=c1x1+c3x3+c5x5+c7x7
  - o1=c3x1-c7x3-c1x5-c5x7
  - o2=c5x1-c1x3+c7x5+c3x7
  - o3=c7x1-c5x3+c3x5-c1x7
- R7: For k=0..3, result k is bits 26..11 of ek+ok and result 7-k is bits 26..11 of ek-ok. The sums are formed without overflow.
- R8: When x1 to x7 are all zero, every lane equals bits 12..0 of x0 followed by three zero bits. This holds even where the weighted path would give a different value.
- R9: Values outside 16 bits wrap: only bits 26..11 of each sum reach the output, with no saturation.
- R10: `out_data` keeps its value until the next `out_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A coefficient row is offered |
| in_ready | output | 1 | The block can accept a row |
| in_coef | input | 128 | Eight signed coefficients, lane k at bits 16k+15..16k |
| out_valid | output | 1 | One-cycle pulse: `out_data` holds a new row |
| out_data | output | 128 | Eight signed results, lane k at bits 16k+15..16k |

## Verification
The bench uses several kinds of rows:
- Full-range random rows exercise every product and butterfly sign.
- Small-magnitude rows catch errors in the rounding bias, where the bias decides the low bits.
- DC-only rows with large x0 tell the shortcut apart from the weighted path, because for such rows the two give different words.
- Rows with a single nonzero AC coefficient check that the shortcut test looks at all seven AC lanes.
- All-maximum, all-minimum and alternating-sign rows drive the sums past 32 bits and test the wrap of the truncation.
- Holding `in_valid` high while a row is in flight checks that a second row is not taken.

// File: rtl/idct8_row.sv
module idct8_row #(
  parameter int DW = 16,
  parameter int AW = 36,
  parameter int SH = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [8*DW-1:0] in_coef,
  output logic            out_valid,
  output logic [8*DW-1:0] out_data
);
  localparam int signed C1 = 22725;
  localparam int signed C2 = 21407;
  localparam int signed C3 = 19266;
  localparam int signed C4 = 16383;
  localparam int signed C5 = 12873;
  localparam int signed C6 = 8867;
  localparam int signed C7 = 4520;
  localparam int signed BIAS = 1 << (SH - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SUM, ST_OUT} st_t;
  st_t st;

  logic signed [DW-1:0] x [8];
  logic signed [AW-1:0] ev_q [4];
  logic signed [AW-1:0] od_q [4];
  logic signed [AW-1:0] ev_d [4];
  logic signed [AW-1:0] od_d [4];
  logic                 dc_q, dc2_q;
  logic [DW-1:0]        dcw_q;
  logic [8*DW-1:0]      res;

  wire accept = in_valid && in_ready;
  wire ac_zero = (in_coef[8*DW-1:DW] == '0);

  assign in_ready = (st == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      dc_q <= 1'b0;
      for (int i = 0; i < 8; i++) x[i] <= '0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          st <= ST_SUM;
          dc_q <= ac_zero;
          for (int i = 0; i < 8; i++) x[i] <= in_coef[i*DW +: DW];
        end
        ST_SUM:  st <= ST_OUT;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ev_d[0] = C4*x[0] + C2*x[2] + C4*x[4] + C6*x[6] + BIAS;
    ev_d[1] = C4*x[0] + C6*x[2] - C4*x[4] - C2*x[6] + BIAS;
    ev_d[2] = C4*x[0] - C6*x[2] - C4*x[4] + C2*x[6] + BIAS;
    ev_d[3] = C4*x[0] - C2*x[2] + C4*x[4] - C6*x[6] + BIAS;
    od_d[0] = C1*x[1] + C3*x[3] + C5*x[5] + C7*x[7];
    od_d[1] = C3*x[1] - C7*x[3] - C1*x[5] - C5*x[7];
    od_d[2] = C5*x[1] - C1*x[3] + C7*x[5] + C3*x[7];
    od_d[3] = C7*x[1] - C5*x[3] + C3*x[5] - C1*x[7];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dc2_q <= 1'b0;
      dcw_q <= '0;
      for (int i = 0; i < 4; i++) begin
        ev_q[i] <= '0;
        od_q[i] <= '0;
      end
    end else if (st == ST_SUM) begin
      dc2_q <= dc_q;
      dcw_q <= {x[0][DW-4:0], 3'b000};
      if (!dc_q) begin
        for (int i = 0; i < 4; i++) begin
          ev_q[i] <= ev_d[i];
          od_q[i] <= od_d[i];
        end
      end
    end
  end

  for (genvar k = 0; k < 4; k++) begin : g_bfly
    logic signed [AW-1:0] lo, hi;
    assign lo = ev_q[k] + od_q[k];
    assign hi = ev_q[k] - od_q[k];
    assign res[k*DW +: DW]     = dc2_q ? dcw_q : lo[SH+DW-1:SH];
    assign res[(7-k)*DW +: DW] = dc2_q ? dcw_q : hi[SH+DW-1:SH];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data <= '0;
    end else begin
      out_valid <= (st == ST_OUT);
      if (st == ST_OUT) out_data <= res;
    end
  end
endmodule

// File: rtl/idct8_row_chk.sv
module idct8_row_chk #(
  parameter int DW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [8*DW-1:0] in_coef,
  input logic            out_valid,
  input logic [8*DW-1:0] out_data
);
  p_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  p_busy2_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> ##2 !in_ready);
  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> ##3 (out_valid && in_ready));
  p_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));
  for (genvar k = 0; k < 8; k++) begin : g_dc
    p_dc_lane_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(in_valid && in_ready && in_coef[8*DW-1:DW] == '0, 3))
      |-> out_data[k*DW +: DW] == {$past(in_coef[DW-4:0], 3), 3'b000});
  end
endmodule

bind idct8_row idct8_row_chk #(.DW(DW)) u_chk (.*);

// File: tb/idct8_row_test.sv
module idct8_row_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [127:0] in_coef = '0;
  logic out_valid;
  logic [127:0] out_data;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  idct8_row uut (.*);

  function automatic logic [127:0] model(input logic [127:0] c);
    longint x [8];
    longint e [4];
    longint o [4];
    longint s;
    logic [127:0] r;
    for (int i = 0; i < 8; i++) x[i] = longint'($signed(c[i*16 +: 16]));
    if (c[127:16] == '0) begin
      for (int i = 0; i < 8; i++) r[i*16 +: 16] = {c[12:0], 3'b000};
      return r;
    end
    e[0] = 16383*x[0] + 21407*x[2] + 16383*x[4] + 8867*x[6] + 1024;
    e[1] = 16383*x[0] + 8867*x[2] - 16383*x[4] - 21407*x[6] + 1024;
    e[2] = 16383*x[0] - 8867*x[2] - 16383*x[4] + 21407*x[6] + 1024;
    e[3] = 16383*x[0] - 21407*x[2] + 16383*x[4] - 8867*x[6] + 1024;
    o[0] = 22725*x[1] + 19266*x[3] + 12873*x[5] + 4520*x[7];
    o[1] = 19266*x[1] - 4520*x[3] - 22725*x[5] - 12873*x[7];
    o[2] = 12873*x[1] - 22725*x[3] + 4520*x[5] + 19266*x[7];
    o[3] = 4520*x[1] - 12873*x[3] + 19266*x[5] - 22725*x[7];
    for (int k = 0; k < 4; k++) begin
      s = e[k] + o[k];
      r[k*16 +: 16] = s[26:11];
      s = e[k] - o[k];
      r[(7-k)*16 +: 16] = s[26:11];
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [127:0] c, input string req, input bit poke);
    logic [127:0] exp = model(c);
    @(negedge clk);
    in_valid = 1'b1;
    in_coef = c;
    @(negedge clk);
    check(in_ready == 1'b0, "R2", {127'b0, in_ready}, 128'd0);
    in_valid = poke;
    in_coef = ~c;
    @(negedge clk);
    check(in_ready == 1'b0 && out_valid == 1'b0, "R2/R3", {126'b0, in_ready, out_valid}, 128'd0);
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b1 && in_ready == 1'b1, "R3", {126'b0, out_valid, in_ready}, 128'd3);
    check(out_data == exp, req, out_data, exp);
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, poke ? "R2" : "R3", {126'b0, out_valid, in_ready}, 128'd1);
    check(out_data == exp, "R10", out_data, exp);
  endtask

  function automatic logic [127:0] rnd_row(input int mag);
    logic [127:0] r;
    for (int i = 0; i < 8; i++) begin
      if (mag == 0) r[i*16 +: 16] = 16'($urandom);
      else r[i*16 +: 16] = 16'($signed($urandom_range(2*mag, 0)) - mag);
    end
    return r;
  endfunction

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1 && out_data == '0, "R1",
          {out_data[125:0], out_valid, in_ready}, 128'd1);
    rst_n = 1'b1;
    send({16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd100}, "R8", 1'b0);
    send({112'd0, 16'sh7fff}, "R8", 1'b0);
    send({112'd0, 16'sh8000}, "R8", 1'b0);
    send({112'd0, 16'shffff}, "R8", 1'b1);
    send({16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd1, 16'sd64}, "R6", 1'b0);
    send({16'sd1, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd64}, "R6", 1'b0);
    send({16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd5, 16'sd0, -16'sd7}, "R5", 1'b0);
    send({8{16'sh7fff}}, "R9", 1'b0);
    send({8{16'sh8000}}, "R9", 1'b0);
    send({4{16'sh8000, 16'sh7fff}}, "R9", 1'b1);
    send({4{16'sh7fff, 16'sh8000}}, "R7", 1'b0);
    send({16'sd8, 16'sd7, 16'sd6, 16'sd5, 16'sd4, 16'sd3, 16'sd2, 16'sd1}, "R4", 1'b0);
    for (int n = 0; n < 300; n++) send(rnd_row(0), "R7", n[2]);
    for (int n = 0; n < 300; n++) send(rnd_row(40), "R5", n[3]);
    for (int n = 0; n < 50; n++) send({112'd0, 16'($urandom)}, "R8", 1'b0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule